// File: doc/BRIEF.md
# Mesh Turn-Table Route Unit

This unit sits beside each input buffer of a router in a two-dimensional mesh network-on-chip. It does not carry flit data. It only looks at the flit at the head of its input FIFO. When that flit opens a packet, the unit compares the packet's destination coordinates with the router's own position. The result gives the quadrant or axis in which the destination lies. The unit then combines that result with a static set of link-presence bits and a programmable set of eight turn permissions. From these it raises registered request lines toward North, East, West, South and Local, which go to the switch allocator.

The requests stay unchanged while the body of the packet passes through. They fall to zero one cycle after the tail flit leaves. The tail counts as gone when it is at the FIFO head, the FIFO holds data, and any grant is present. Software can change the turn permissions through a reconfiguration pulse. The pulse only arms a pending flag, and the new permissions are taken in at the next tail departure, so a packet in flight never sees its routing rule change. The request lines are plain levels with no handshake: the allocator answers through the grant inputs, and the unit applies no back-pressure of its own.

Top module: `mesh_route_unit`

## Requirements
- R1: An asynchronous low reset clears every request and the pending flag, and loads the turn permissions from `route_cfg_i`.
- R2: When the FIFO is not empty and the head flit type field `flit_i[31:29]` is 3'b001 (header), the requests are updated on the next clock edge. They are derived from the destination X in `flit_i[2:0]` and Y in `flit_i[5:3]`, compared with the router position. A smaller Y lies north and a larger X lies east. `req_o` bits are {N,E,W,S,L} from bit 4 down to bit 0.
- R3: A body flit (type 3'b010), an empty FIFO, or a tail with no grant leaves the requests unchanged, whatever the destination field holds.
- R4: A tail flit (type 3'b100) with the FIFO not empty and any bit of `grant_i` set clears all requests on the next edge.
- R5: A destination equal to the router position raises only Local. Any other destination leaves Local low.
- R6: A direction whose connectivity bit is 0 is never requested. `CONN` bits are {N,E,W,S} from bit 3 down to bit 0.
- R7: The direction of the unit's own input port, given by `IN_PORT`, is never requested.
- R8: A straight move along one axis is always allowed. A diagonal destination requests direction D only if the permission for "travelling D, turning toward the other axis" is set. The permission bits, from bit 7 down to bit 0, are: north-to-east, north-to-west, east-to-north, east-to-south, west-to-north, west-to-south, south-to-east, south-to-west. With permissions 8'b00111100, at most one request is active.
- R9: No more than two requests are ever active at once.
- R10: A high `reconf_i` arms a pending update. The permissions reload from `route_cfg_i` only at a tail departure while the update is pending, and that departure clears the pending flag.
- R11: A change on `route_cfg_i` with no pending update has no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | Input FIFO has no flit |
| flit_i | input | 32 | Flit at the FIFO head (type, destination fields) |
| grant_i | input | 5 | Allocator grants {N,E,W,S,L} |
| reconf_i | input | 1 | Request to replace the turn permissions |
| route_cfg_i | input | 8 | New turn-permission vector |
| req_o | output | 5 | Registered requests {N,E,W,S,L} |

## Verification
The assertions assume that `route_cfg_i` is held steady while reset is low. They also assume that a header flit is never presented in the same cycle as a tail departure. The bench respects both conditions: it changes the configuration only with the FIFO idle, and it sends packets as separate header, body and tail phases. The turn-limit properties assume a loaded permission vector whose diagonals allow at most one turn per quadrant pair. The stimulus therefore uses only the XY vector, the all-open vector and the all-closed vector. The diagonal destinations in the stimulus cover both tests, with and without a pending update.

// File: rtl/mru_pkg.sv
package mru_pkg;
  localparam int NREQ = 5;
  localparam int IDX_N = 4;
  localparam int IDX_E = 3;
  localparam int IDX_W = 2;
  localparam int IDX_S = 1;
  localparam int IDX_L = 0;

  localparam logic [2:0] FT_HEAD = 3'b001;
  localparam logic [2:0] FT_BODY = 3'b010;
  localparam logic [2:0] FT_TAIL = 3'b100;

  typedef struct packed {
    logic n;
    logic e;
    logic w;
    logic s;
  } quad_t;
endpackage

// File: rtl/mru_quadrant.sv
module mru_quadrant #(
  parameter int X_W = 3,
  parameter int Y_W = 3,
  parameter int CUR_X = 3,
  parameter int CUR_Y = 3
) (
  input  logic [X_W-1:0] dst_x_i,
  input  logic [Y_W-1:0] dst_y_i,
  output mru_pkg::quad_t quad_o,
  output logic           here_o
);
  localparam logic [X_W-1:0] MY_X = X_W'(CUR_X);
  localparam logic [Y_W-1:0] MY_Y = Y_W'(CUR_Y);

  always_comb begin
    quad_o.n = dst_y_i < MY_Y;
    quad_o.s = dst_y_i > MY_Y;
    quad_o.e = dst_x_i > MY_X;
    quad_o.w = dst_x_i < MY_X;
    here_o   = (dst_x_i == MY_X) && (dst_y_i == MY_Y);
  end
endmodule

// File: rtl/mru_turn_logic.sv
module mru_turn_logic #(
  parameter logic [3:0] CONN = 4'b1111,
  parameter int IN_PORT = 0
) (
  input  mru_pkg::quad_t  quad_i,
  input  logic            here_i,
  input  logic [7:0]      perm_i,
  output logic [mru_pkg::NREQ-1:0] req_o
);
  import mru_pkg::*;
  logic [NREQ-1:0] raw;

  always_comb begin
    raw = '0;
    raw[IDX_N] = quad_i.n & ((!quad_i.e & !quad_i.w) | (quad_i.e & perm_i[7]) | (quad_i.w & perm_i[6]));
    raw[IDX_E] = quad_i.e & ((!quad_i.n & !quad_i.s) | (quad_i.n & perm_i[5]) | (quad_i.s & perm_i[4]));
    raw[IDX_W] = quad_i.w & ((!quad_i.n & !quad_i.s) | (quad_i.n & perm_i[3]) | (quad_i.s & perm_i[2]));
    raw[IDX_S] = quad_i.s & ((!quad_i.e & !quad_i.w) | (quad_i.e & perm_i[1]) | (quad_i.w & perm_i[0]));
    raw[IDX_N:IDX_S] = raw[IDX_N:IDX_S] & CONN;
    raw[IDX_L] = here_i;
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_mask
    if (i == IN_PORT) begin : g_uturn
      assign req_o[i] = 1'b0;
    end else begin : g_pass
      assign req_o[i] = raw[i];
    end
  end
endmodule

// File: rtl/mru_cfg_reg.sv
module mru_cfg_reg #(
  parameter int PERM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reconf_i,
  input  logic [PERM_W-1:0] cfg_i,
  input  logic              depart_i,
  output logic [PERM_W-1:0] perm_o,
  output logic              pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_o <= cfg_i;
      pend_o <= 1'b0;
    end else if (pend_o && depart_i) begin
      perm_o <= cfg_i;
      pend_o <= 1'b0;
    end else if (reconf_i) begin
      pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit #(
  parameter int FLIT_W = 32,
  parameter int X_W = 3,
  parameter int Y_W = 3,
  parameter int DX_LSB = 0,
  parameter int DY_LSB = 3,
  parameter int CUR_X = 3,
  parameter int CUR_Y = 3,
  parameter logic [3:0] CONN = 4'b1110,
  parameter int IN_PORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty_i,
  input  logic [FLIT_W-1:0] flit_i,
  input  logic [4:0]        grant_i,
  input  logic              reconf_i,
  input  logic [7:0]        route_cfg_i,
  output logic [4:0]        req_o
);
  import mru_pkg::*;
  localparam int TYPE_LSB = FLIT_W - 3;

  logic [2:0]     flit_type;
  logic [X_W-1:0] dst_x;
  logic [Y_W-1:0] dst_y;
  logic           is_head;
  logic           depart;
  quad_t          quad;
  logic           here;
  logic [7:0]     route_bits;
  logic           pend;
  logic [NREQ-1:0] req_next;

  assign flit_type = flit_i[TYPE_LSB +: 3];
  assign dst_x     = flit_i[DX_LSB +: X_W];
  assign dst_y     = flit_i[DY_LSB +: Y_W];
  assign is_head   = !fifo_empty_i && (flit_type == FT_HEAD);
  assign depart    = !fifo_empty_i && (flit_type == FT_TAIL) && (|grant_i);

  mru_quadrant #(.X_W(X_W), .Y_W(Y_W), .CUR_X(CUR_X), .CUR_Y(CUR_Y)) quad_i (
    .dst_x_i(dst_x), .dst_y_i(dst_y), .quad_o(quad), .here_o(here));

  mru_turn_logic #(.CONN(CONN), .IN_PORT(IN_PORT)) turn_i (
    .quad_i(quad), .here_i(here), .perm_i(route_bits), .req_o(req_next));

  mru_cfg_reg #(.PERM_W(8)) cfg_i (
    .clk(clk), .rst_n(rst_n), .reconf_i(reconf_i), .cfg_i(route_cfg_i),
    .depart_i(depart), .perm_o(route_bits), .pend_o(pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_o <= '0;
    else if (is_head) req_o <= req_next;
    else if (depart)  req_o <= '0;
  end
endmodule

// File: rtl/mesh_route_unit_chk.sv
module mesh_route_unit_chk #(
  parameter logic [3:0] CONN = 4'b1110,
  parameter int IN_PORT = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_empty_i,
  input logic [2:0] flit_type,
  input logic [4:0] grant_i,
  input logic       reconf_i,
  input logic [4:0] req_o,
  input logic [7:0] route_bits,
  input logic       pend
);
  logic tail_go;
  assign tail_go = !fifo_empty_i && flit_type == 3'b100 && (|grant_i);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> req_o == 5'b0 && !pend);
  // R3
  body_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty_i || flit_type == 3'b010) |=> $stable(req_o));
  // R4
  tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_go |=> req_o == 5'b0);
  // R5
  local_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[0] |-> req_o[4:1] == 4'b0);
  // R6
  no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o[4:1] & ~CONN) == 4'b0);
  // R7
  no_uturn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o[IN_PORT]);
  // R8
  xy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_bits == 8'b00111100 |-> $onehot0(req_o));
  // R9
  two_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_o) <= 2);
  // R10
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf_i && !tail_go) |=> pend);
  // R11
  perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && tail_go) |=> $stable(route_bits));
endmodule

bind mesh_route_unit mesh_route_unit_chk #(.CONN(CONN), .IN_PORT(IN_PORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i), .flit_type(flit_type),
  .grant_i(grant_i), .reconf_i(reconf_i), .req_o(req_o),
  .route_bits(route_bits), .pend(pend));

// File: tb/mesh_route_unit_tb_top.sv
module mesh_route_unit_tb_top;
  localparam time CLK_PERIOD = 10;
  localparam int CX = 3;
  localparam int CY = 3;
  localparam logic [3:0] CONN = 4'b1110;
  localparam int IN_PORT = 2;

  logic clk, rst_n, fifo_empty_i, reconf_i;
  logic [31:0] flit_i;
  logic [4:0] grant_i, req_o;
  logic [7:0] route_cfg_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  mesh_route_unit #(.CUR_X(CX), .CUR_Y(CY), .CONN(CONN), .IN_PORT(IN_PORT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i), .flit_i(flit_i),
    .grant_i(grant_i), .reconf_i(reconf_i), .route_cfg_i(route_cfg_i), .req_o(req_o));

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Reference: expected requests from the destination offset and permissions
  function automatic logic [4:0] ref_route(int dx, int dy, logic [7:0] b);
    int ox = dx - CX;
    int oy = dy - CY;
    logic [4:0] r = '0;
    if (ox == 0 && oy == 0) r[0] = 1'b1;
    else begin
      if (oy < 0) r[4] = (ox == 0) ? 1'b1 : (ox > 0 ? b[7] : b[6]);
      if (ox > 0) r[3] = (oy == 0) ? 1'b1 : (oy < 0 ? b[5] : b[4]);
      if (ox < 0) r[2] = (oy == 0) ? 1'b1 : (oy < 0 ? b[3] : b[2]);
      if (oy > 0) r[1] = (ox == 0) ? 1'b1 : (ox > 0 ? b[1] : b[0]);
    end
    if (!CONN[3]) r[4] = 1'b0;
    if (!CONN[2]) r[3] = 1'b0;
    if (!CONN[1]) r[2] = 1'b0;
    if (!CONN[0]) r[1] = 1'b0;
    r[IN_PORT] = 1'b0;
    return r;
  endfunction

  logic [4:0] m_req;
  logic [7:0] m_bits;
  bit m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= '0;
      m_pend <= 0;
      m_bits <= route_cfg_i;
    end else begin
      bit gone;
      gone = !fifo_empty_i && flit_i[31:29] == 3'b100 && grant_i != 0;
      if (!fifo_empty_i && flit_i[31:29] == 3'b001)
        m_req <= ref_route(int'(flit_i[2:0]), int'(flit_i[5:3]), m_bits);
      else if (gone)
        m_req <= '0;
      if (m_pend && gone) begin
        m_bits <= route_cfg_i;
        m_pend <= 0;
      end else if (reconf_i) m_pend <= 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (req_o !== m_req) begin
        n_bad++;
        $display("FAIL %s: req_o=%b expected %b at %0t", tag, req_o, m_req, $time);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    fifo_empty_i = 1; grant_i = 0; reconf_i = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_pkt(int dx, int dy, string t);
    tag = t;
    step();
    fifo_empty_i = 0; grant_i = 0;
    flit_i = {3'b001, 23'b0, 3'(dy), 3'(dx)};
    step();
    // body flits with unrelated destination bits: ignored (R3)
    flit_i = {3'b010, 23'b0, 3'd3, 3'd3};
    step();
    fifo_empty_i = 1;
    step();
    fifo_empty_i = 0;
    flit_i = {3'b010, 23'b0, 3'd0, 3'd6};
    step();
    // tail waiting for a grant holds requests (R3), then leaves (R4)
    flit_i = {3'b100, 23'b0, 3'd1, 3'd1};
    step();
    grant_i = 5'b01000;
    step();
    idle(2);
  endtask

  task automatic do_reset(logic [7:0] cfg);
    tag = "R1";
    route_cfg_i = cfg;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(2);
  endtask

  initial begin
    rst_n = 0; fifo_empty_i = 1; grant_i = 0; reconf_i = 0;
    flit_i = '0; route_cfg_i = 8'b00111100;
    do_reset(8'b00111100);
    send_pkt(5, 1, "R8");   // north-east under XY: east only
    send_pkt(3, 3, "R5");   // own address: local only
    send_pkt(3, 0, "R2");   // straight north
    send_pkt(3, 6, "R6");   // south link absent: nothing
    send_pkt(0, 3, "R7");   // west is own input: nothing
    send_pkt(6, 5, "R8");   // south-east under XY: east only
    // arm an update with the FIFO idle; it waits for a tail
    tag = "R10";
    route_cfg_i = 8'hFF;
    reconf_i = 1;
    step();
    idle(2);
    send_pkt(5, 1, "R10");  // still old permissions
    send_pkt(5, 1, "R9");   // all turns open: north and east
    send_pkt(1, 0, "R9");   // north-west: north only (west masked)
    tag = "R11";
    route_cfg_i = 8'h00;
    idle(2);
    send_pkt(5, 1, "R11");  // unchanged: north and east
    do_reset(8'h00);
    send_pkt(5, 1, "R1");   // no turns loaded at reset: nothing
    send_pkt(3, 3, "R5");
    send_pkt(6, 3, "R2");   // straight east
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule